// File: doc/BRIEF.md
# Peripheral Reference Clock Selector and Divider

This block turns one input tick stream into two peripheral reference tick enables in the system clock domain. The input stream feeds three PLL stages: io, cpu and mem. Each stage has its own control word, and the stage either passes the stream on, passes it on in bypass, or goes silent. Frequency multiplication is not modelled, so an enabled stage passes the input ticks through as they arrive.

A shared clock control word drives the rest of the path. A 2-bit field picks one of the three stages. A 6-bit field sets an integer divisor applied to the ticks of the chosen stage. Two enable bits gate the divided stream onto the two outputs. Each output tick lasts one cycle and comes from a register.

The divider keeps its own copy of the selector and divisor fields. When either field at the input differs from that copy, the count starts again from zero.

Top module: `periph_refclk_gen`

## Requirements
- R1: The divisor sits in clk_ctrl bits [13:8]. A value N from 1 to 63 makes the outputs tick once every N ticks of the selected stage. With a source tick in every cycle, output ticks are exactly N cycles apart.
- R2: A divisor field of 0 divides by 1, so one output tick follows each source tick.
- R3: The selector sits in clk_ctrl bits [5:4]. Codes 0 and 1 both choose the io stage, code 2 chooses the cpu stage and code 3 chooses the mem stage.
- R4: A stage whose control word has bit 4 (bypass) set passes the input ticks unchanged, whatever its bits 0 and 1 hold.
- R5: A stage without bypass whose bit 0 (reset) or bit 1 (powerdown) is set produces no ticks.
- R6: out_tick[0] is gated by clk_ctrl bit 0 and out_tick[1] by clk_ctrl bit 1. A cleared bit keeps that output low from the next cycle on.
- R7: While rst_n is low, both outputs are low.
- R8: Reset leaves the divider's copy of the fields at divisor 63, selector 0. If clk_ctrl is 0x00003F03 when reset is released, with a source tick in every cycle, the first tick is seen in the 63rd cycle.
- R9: When the divisor or selector field changes, the count restarts. With a source tick in every cycle, the first tick after the change appears N+1 cycles after the cycle in which the new value was presented, where N is the effective divisor.
- R10: Every output tick follows a source tick of the selected stage one cycle earlier. A source ticking once every K cycles gives output ticks K*N cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Input clock tick enable feeding all three stages |
| io_pll_ctrl | input | 32 | io stage control word (bit 0 reset, bit 1 powerdown, bit 4 bypass) |
| cpu_pll_ctrl | input | 32 | cpu stage control word, same layout |
| mem_pll_ctrl | input | 32 | mem stage control word, same layout |
| clk_ctrl | input | 32 | Enables in bits 1:0, selector in bits 5:4, divisor in bits 13:8 |
| out_tick | output | 2 | Output tick enables, one cycle wide |

## Verification
A stuck or off-by-one divider count shows up at the outputs within one divided period: the spacing between ticks comes out wrong, or ticks stop. A stale copy of the selector or divisor moves the first tick after a change away from N+1 cycles. A wrong mux decode or a wrong stage state shows up as ticks that appear or vanish within a few source ticks of a selector or stage change. A bad reset value for the stored fields moves the first tick after reset from cycle 63 to cycle 64.

// File: rtl/refclk_pkg.sv
package refclk_pkg;
   // clock control word layout
   localparam int EN_LSB   = 0;
   localparam int NUM_OUT  = 2;
   localparam int SEL_LSB  = 4;
   localparam int SEL_W    = 2;
   localparam int DIV_LSB  = 8;
   localparam int DIV_W    = 6;
   // PLL stage control word layout
   localparam int PLL_RST_BIT = 0;
   localparam int PLL_PD_BIT  = 1;
   localparam int PLL_BYP_BIT = 4;
   localparam int NUM_SRC     = 3;
   // state held by the divider after reset
   localparam logic [DIV_W-1:0] DIV_RST = 6'd63;
   localparam logic [SEL_W-1:0] SEL_RST = 2'd0;

   typedef enum logic [1:0] {
      SRC_IO  = 2'd0,
      SRC_CPU = 2'd1,
      SRC_MEM = 2'd2
   } src_idx_e;

   function automatic src_idx_e decode_sel(input logic [SEL_W-1:0] code);
      case (code)
         2'd2:    decode_sel = SRC_CPU;
         2'd3:    decode_sel = SRC_MEM;
         default: decode_sel = SRC_IO;
      endcase
   endfunction
endpackage

// File: rtl/refclk_pll_stage.sv
module refclk_pll_stage
   import refclk_pkg::*;
#(
   parameter int CTRL_W = 32
) (
   input  logic [CTRL_W-1:0] ctrl,
   input  logic              tick_in,
   output logic              tick_out
);
   generate
      if (CTRL_W <= PLL_BYP_BIT) begin : g_bad_w
         $error("refclk_pll_stage: CTRL_W too narrow for bypass bit");
      end
   endgenerate

   logic bypass, halted;

   always_comb begin
      bypass = ctrl[PLL_BYP_BIT];
      halted = ctrl[PLL_RST_BIT] | ctrl[PLL_PD_BIT];
      if (bypass)      tick_out = tick_in;
      else if (halted) tick_out = 1'b0;
      else             tick_out = tick_in;  // multiplication not modelled
   end
endmodule

// File: rtl/refclk_src_mux.sv
module refclk_src_mux
   import refclk_pkg::*;
(
   input  logic [NUM_SRC-1:0] stage_tick,
   input  logic [SEL_W-1:0]   sel,
   output logic              tick
);
   src_idx_e idx;

   always_comb begin
      idx  = decode_sel(sel);
      tick = stage_tick[idx];
   end
endmodule

// File: rtl/refclk_divider.sv
module refclk_divider
   import refclk_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             src_tick,
   input  logic [DIV_W-1:0] div_in,
   input  logic [SEL_W-1:0] sel_in,
   output logic             fire
);
   logic [DIV_W-1:0] cnt_q, div_q, lim_m1;
   logic [SEL_W-1:0] sel_q;
   logic             restart;

   always_comb begin
      restart = (div_in != div_q) || (sel_in != sel_q);
      lim_m1  = (div_q == '0) ? '0 : div_q - 1'b1;
      fire    = !restart && src_tick && (cnt_q == lim_m1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         div_q <= DIV_RST;
         sel_q <= SEL_RST;
      end else if (restart) begin
         cnt_q <= '0;
         div_q <= div_in;
         sel_q <= sel_in;
      end else if (src_tick) begin
         cnt_q <= fire ? '0 : cnt_q + 1'b1;
      end
   end

   // R1: the count never passes the stored limit
   a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= lim_m1);

   // R9: a field change always restarts the count
   a_r9_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ((div_in != div_q) || (sel_in != sel_q)) |=> (cnt_q == '0));
endmodule

// File: rtl/periph_refclk_gen.sv
module periph_refclk_gen
   import refclk_pkg::*;
#(
   parameter int PLL_W  = 32,
   parameter int CTRL_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_tick,
   input  logic [PLL_W-1:0]  io_pll_ctrl,
   input  logic [PLL_W-1:0]  cpu_pll_ctrl,
   input  logic [PLL_W-1:0]  mem_pll_ctrl,
   input  logic [CTRL_W-1:0] clk_ctrl,
   output logic [NUM_OUT-1:0] out_tick
);
   localparam int CTRL_MIN = DIV_LSB + DIV_W;

   generate
      if (CTRL_W < CTRL_MIN) begin : g_bad_ctrl
         $error("periph_refclk_gen: CTRL_W below %0d", CTRL_MIN);
      end
   endgenerate

   logic [PLL_W-1:0]   pll_ctrl [NUM_SRC];
   logic [NUM_SRC-1:0] stage_tick;
   logic               mux_tick, fire;
   logic [NUM_OUT-1:0] out_q;

   assign pll_ctrl[SRC_IO]  = io_pll_ctrl;
   assign pll_ctrl[SRC_CPU] = cpu_pll_ctrl;
   assign pll_ctrl[SRC_MEM] = mem_pll_ctrl;

   generate
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_stage
         refclk_pll_stage #(.CTRL_W(PLL_W)) u_stage (
            .ctrl     (pll_ctrl[s]),
            .tick_in  (ref_tick),
            .tick_out (stage_tick[s])
         );
      end
   endgenerate

   refclk_src_mux u_mux (
      .stage_tick (stage_tick),
      .sel        (clk_ctrl[SEL_LSB +: SEL_W]),
      .tick       (mux_tick)
   );

   refclk_divider u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_tick (mux_tick),
      .div_in   (clk_ctrl[DIV_LSB +: DIV_W]),
      .sel_in   (clk_ctrl[SEL_LSB +: SEL_W]),
      .fire     (fire)
   );

   generate
      for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q[o] <= 1'b0;
            else        out_q[o] <= fire & clk_ctrl[EN_LSB + o];
         end

         // R6: a cleared enable silences its output on the next cycle
         a_r6_gate: assert property (@(posedge clk) disable iff (!rst_n)
            !clk_ctrl[EN_LSB + o] |=> !out_q[o]);
      end
   endgenerate

   assign out_tick = out_q;

   // R7: outputs stay low while reset is held
   a_r7_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> (out_tick == '0));

   // R10: every output tick follows a selected-source tick
   a_r10_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
      (out_tick != '0) |-> $past(mux_tick));
endmodule

// File: tb/tb_periph_refclk_gen.sv
`timescale 1ns/1ps
module tb_periph_refclk_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_tick = 1'b1;
   logic [31:0] io_ctl = 32'h0, cpu_ctl = 32'h0, mem_ctl = 32'h0;
   logic [31:0] cctl = 32'h0000_3F03;
   logic [1:0]  out_tick;
   int          n_chk = 0, n_bad = 0;
   int          src_per = 1, ph = 0;
   int          cyc = 0;

   always #2 clk = ~clk;

   periph_refclk_gen dut (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
      .io_pll_ctrl(io_ctl), .cpu_pll_ctrl(cpu_ctl), .mem_pll_ctrl(mem_ctl),
      .clk_ctrl(cctl), .out_tick(out_tick));

   always @(negedge clk) begin
      if (src_per <= 1) begin
         ref_tick <= 1'b1;
         ph = 0;
      end else begin
         ref_tick <= (ph == 0);
         ph = (ph + 1 == src_per) ? 0 : ph + 1;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input int dv, input int sel, input int en);
      mk = (32'(dv) << 8) | (32'(sel) << 4) | 32'(en);
   endfunction

   // samples until out_tick[b] is seen high; 0 on timeout
   task automatic wait_next(input int b, input int lim, output int k);
      k = 0;
      for (int i = 1; i <= lim; i++) begin
         @(negedge clk);
         if (out_tick[b]) begin k = i; return; end
      end
   endtask

   task automatic count_hi(input int b, input int w, output int c);
      c = 0;
      for (int i = 0; i < w; i++) begin
         @(negedge clk);
         if (out_tick[b]) c++;
      end
   endtask

   task automatic t_reset;
      int k;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check("R7 reset silent", out_tick, 0);
      end
      rst_n = 1'b1;
      wait_next(0, 200, k);
      check("R8 first tick after reset", k, 63);
      wait_next(0, 200, k);
      check("R1 interval 63", k, 63);
   endtask

   task automatic t_div(input int dv, input int per, input int exp_lat,
                        input int exp_int, input string req);
      int k;
      src_per = per;
      @(negedge clk);
      cctl = mk(dv, 0, 3);
      wait_next(0, 1000, k);
      if (exp_lat > 0) check({req, " latency"}, k, exp_lat);
      wait_next(0, 1000, k);
      check({req, " interval"}, k, exp_int);
      wait_next(1, 1000, k);
      check({req, " out1 interval"}, k, exp_int);
      src_per = 1;
   endtask

   task automatic t_mux;
      int c;
      @(negedge clk);
      io_ctl = 32'h1; cpu_ctl = 32'h0; mem_ctl = 32'h2;
      cctl = mk(2, 0, 1);
      count_hi(0, 30, c); check("R3 code0 io off", c, 0);
      cctl = mk(2, 1, 1);
      count_hi(0, 30, c); check("R3 code1 io off", c, 0);
      cctl = mk(2, 2, 1);
      count_hi(0, 30, c); check("R3 code2 cpu on", c > 0, 1);
      cctl = mk(2, 3, 1);
      count_hi(0, 30, c); check("R5 powerdown silent", c, 0);
      mem_ctl = 32'h13;
      count_hi(0, 30, c); check("R4 bypass over reset/pd", c > 0, 1);
      cpu_ctl = 32'h1;
      cctl = mk(2, 2, 1);
      count_hi(0, 30, c); check("R5 reset bit silent", c, 0);
      io_ctl = 32'h0; cpu_ctl = 32'h0; mem_ctl = 32'h0;
   endtask

   task automatic t_enable;
      int c;
      @(negedge clk);
      cctl = mk(3, 0, 1);
      count_hi(1, 30, c); check("R6 out1 gated", c, 0);
      count_hi(0, 30, c); check("R6 out0 active", c, 10);
      cctl = mk(3, 0, 2);
      count_hi(0, 30, c); check("R6 out0 gated", c, 0);
      count_hi(1, 30, c); check("R6 out1 active", c, 10);
   endtask

   task automatic t_restart;
      int k;
      @(negedge clk);
      cctl = mk(4, 0, 3);
      wait_next(0, 100, k);
      wait_next(0, 100, k);
      repeat (2) @(negedge clk);
      cctl = mk(7, 0, 3);
      wait_next(0, 100, k);
      check("R9 restart latency div7", k, 8);
      cctl = mk(7, 1, 3);
      wait_next(0, 100, k);
      check("R9 restart on selector change", k, 8);
   endtask

   initial begin
      int k;
      t_reset();
      t_div(5, 1, 6, 5, "R1 div5");
      t_div(1, 1, 2, 1, "R1 div1");
      t_div(0, 1, 2, 1, "R2 div0");
      t_div(3, 2, 0, 6, "R10 half-rate src");
      t_mux();
      t_enable();
      t_restart();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule